// File: doc/BRIEF.md
# Serial Port Interrupt Identification and Priority Logic

This block collects the five interrupt causes of a 16550-style serial port: line error or break, receive data at or above the trigger level, receive timeout, transmit holding register empty, and modem line change. It keeps a pending flag for each cause, masks the flags with per-cause enables, and reports the most urgent enabled cause in a read-only identification byte. A single registered interrupt line goes to the host. The shifters, FIFOs, baud generator and timeout counter sit outside the block. They reach it as event pulses, a FIFO-level flag and host access strobes.

Each cause has its own acknowledge. A line-status read clears the line cause. The receive-data cause follows the FIFO level. A receive FIFO read clears the timeout. A holding-register write clears the transmit cause. A modem-status read clears the modem cause. While the host holds the identification read strobe, the reported byte, the interrupt line and all pending flags stay frozen. Events that arrive in that window are stored and merged when the access ends. A transmit-empty cause that the frozen byte was reporting is acknowledged at that point.

Top module: `uart_irq_id`

## Requirements
- R1: A synchronous active-high reset clears all pending state, so `iir_q` reads 0x01 and `irq` is 0 on the first clock after reset.
- R2: `iir_q[0]` is active low: it is 0 exactly when an enabled cause is pending. `irq` is 1 under the same condition.
- R3: `iir_q[3:1]` gives the reported cause: 011 line status, 010 receive data, 110 receive timeout, 001 transmit empty, 000 modem change. It reads 000 when nothing is pending.
- R4: Priority runs line status first, then receive data, then timeout, then transmit empty, then modem change. Receive data wins over timeout when both are pending.
- R5: `iir_q[7:6]` both equal `fifo_mode`, and `iir_q[5:4]` always read 0.
- R6: A cause whose enable bit in `src_en` is 0 never drives `irq` or the identification field. Its pending flag is kept and shows once the cause is enabled. Enable bit order: 0 line, 1 rx data, 2 timeout, 3 transmit empty, 4 modem.
- R7: A `ls_rd` pulse clears the line-status cause. A `msr_rd` pulse clears the modem cause.
- R8: The receive-data cause follows `rx_at_trig`. A `rxf_rd` pulse clears the timeout cause.
- R9: A `thr_wr` pulse clears the transmit-empty cause. When an identification access ends, transmit empty is cleared only if it was the cause that access reported.
- R10: While `iir_rd` is 1, `iir_q`, `irq` and all pending flags hold. Events in that window are applied after the access ends. Clear strobes in that window have no effect.
- R11: When a cause's event and its clear strobe arrive in the same cycle, the cause stays pending.
- R12: Outputs are registered and change only on the clock edge after the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_mode | input | 1 | FIFO mode enabled; copied into bits 7:6 |
| src_en | input | 5 | Per-cause interrupt enables |
| ls_evt | input | 1 | Line error or break event pulse |
| ls_rd | input | 1 | Host read of line status register |
| rx_at_trig | input | 1 | Receive FIFO level at or above trigger |
| tmo_evt | input | 1 | Receive timeout with data event pulse |
| rxf_rd | input | 1 | Host read of receive FIFO |
| thre_evt | input | 1 | Transmit holding register became empty |
| thr_wr | input | 1 | Host write of transmit holding register |
| ms_evt | input | 1 | Modem line change event pulse |
| msr_rd | input | 1 | Host read of modem status register |
| iir_rd | input | 1 | Host identification read in progress |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle:
- the reset value;
- the agreement between `irq` and the active-low pending bit;
- the legal cause codes and the fixed-zero bits;
- the hold of the outputs during an identification access;
- the line-status clear.

Only the bench's scenarios can show:
- the priority ordering among several pending causes;
- the enable masking with a flag kept while masked;
- capture and replay of events during a frozen access;
- the conditional transmit-empty acknowledge.

A behavioural model in the bench covers these and is compared with the outputs on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC = 5;

    // Cause index doubles as priority rank: lower index is more urgent.
    localparam int SRC_LS   = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_TMO  = 2;
    localparam int SRC_THRE = 3;
    localparam int SRC_MS   = 4;

    typedef enum logic [2:0] {
        ID_MS   = 3'b000,
        ID_THRE = 3'b001,
        ID_RXD  = 3'b010,
        ID_LS   = 3'b011,
        ID_TMO  = 3'b110
    } irq_id_e;

    typedef struct packed {
        logic    fifo_hi;
        logic    fifo_lo;
        logic [1:0] rsvd;
        irq_id_e id;
        logic    idle;     // active-low pending indicator
    } iir_t;

    localparam iir_t IIR_RESET = '{fifo_hi: 1'b0, fifo_lo: 1'b0, rsvd: 2'b00,
                                   id: ID_MS, idle: 1'b1};

    function automatic irq_id_e src_code(input int idx);
        case (idx)
            SRC_LS:   return ID_LS;
            SRC_RXD:  return ID_RXD;
            SRC_TMO:  return ID_TMO;
            SRC_THRE: return ID_THRE;
            default:  return ID_MS;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] pend_nxt
);

    logic [N-1:0] cap;

    for (genvar i = 0; i < N; i++) begin : g_src
        if (i == SRC_RXD) begin : g_level
            // Level-following cause: tracks the FIFO threshold flag.
            always_comb pend_nxt[i] = hold ? pend[i] : (set_ev[i] & ~clr[i]);
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend[i] <= 1'b0;
                    cap[i]  <= 1'b0;
                end else begin
                    pend[i] <= pend_nxt[i];
                    cap[i]  <= 1'b0;
                end
            end
        end else begin : g_event
            always_comb begin
                if (hold) pend_nxt[i] = pend[i];
                else      pend_nxt[i] = (pend[i] & ~clr[i]) | set_ev[i] | cap[i];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend[i] <= 1'b0;
                    cap[i]  <= 1'b0;
                end else if (hold) begin
                    cap[i]  <= cap[i] | set_ev[i];
                end else begin
                    pend[i] <= pend_nxt[i];
                    cap[i]  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] act,
    output logic         any,
    output irq_id_e      id
);

    always_comb begin
        any = 1'b0;
        id  = ID_MS;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) begin
                any = 1'b1;
                id  = src_code(i);
            end
        end
    end

endmodule

// File: rtl/irq_id_reg.sv
module irq_id_reg
    import uart_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    fifo_mode,
    input  logic    nxt_any,
    input  irq_id_e nxt_id,
    output iir_t    iir,
    output logic    irq,
    output logic    acc_end
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            iir    <= IIR_RESET;
            irq    <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold;
            if (!hold) begin
                iir.fifo_hi <= fifo_mode;
                iir.fifo_lo <= fifo_mode;
                iir.rsvd    <= 2'b00;
                iir.id      <= nxt_any ? nxt_id : ID_MS;
                iir.idle    <= ~nxt_any;
                irq         <= nxt_any;
            end
        end
    end

    assign acc_end = hold_q & ~hold;

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_mode,
    input  logic [4:0] src_en,
    input  logic       ls_evt,
    input  logic       ls_rd,
    input  logic       rx_at_trig,
    input  logic       tmo_evt,
    input  logic       rxf_rd,
    input  logic       thre_evt,
    input  logic       thr_wr,
    input  logic       ms_evt,
    input  logic       msr_rd,
    input  logic       iir_rd,
    output logic [7:0] iir_q,
    output logic       irq
);

    logic [NSRC-1:0] set_ev, clr, pend, pend_nxt;
    logic            nxt_any, acc_end, thre_ack;
    irq_id_e         nxt_id;
    iir_t            iir;

    // Transmit-empty is acknowledged by an access only if it was reported.
    assign thre_ack = acc_end & ~iir.idle & (iir.id == ID_THRE);

    always_comb begin
        set_ev           = '0;
        set_ev[SRC_LS]   = ls_evt;
        set_ev[SRC_RXD]  = rx_at_trig;
        set_ev[SRC_TMO]  = tmo_evt;
        set_ev[SRC_THRE] = thre_evt;
        set_ev[SRC_MS]   = ms_evt;
        clr              = '0;
        clr[SRC_LS]      = ls_rd;
        clr[SRC_TMO]     = rxf_rd;
        clr[SRC_THRE]    = thr_wr | thre_ack;
        clr[SRC_MS]      = msr_rd;
    end

    irq_src_flags #(.N(NSRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .hold     (iir_rd),
        .set_ev   (set_ev),
        .clr      (clr),
        .pend     (pend),
        .pend_nxt (pend_nxt)
    );

    irq_prio_enc #(.N(NSRC)) u_enc (
        .act (pend_nxt & src_en),
        .any (nxt_any),
        .id  (nxt_id)
    );

    irq_id_reg u_idreg (
        .clk       (clk),
        .rst       (rst),
        .hold      (iir_rd),
        .fifo_mode (fifo_mode),
        .nxt_any   (nxt_any),
        .nxt_id    (nxt_id),
        .iir       (iir),
        .irq       (irq),
        .acc_end   (acc_end)
    );

    assign iir_q = iir;

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
    input logic       clk,
    input logic       rst,
    input logic       iir_rd,
    input logic       ls_rd,
    input logic       ls_evt,
    input logic       irq,
    input logic [7:0] iir_q,
    input logic [4:0] pend
);

    assert_reset_value_R1: assert property (@(posedge clk)
        $fell(rst) |-> (iir_q == 8'h01 && !irq));

    assert_pending_polarity_R2: assert property (@(posedge clk) disable iff (rst)
        iir_q[0] == !irq);

    assert_legal_code_R3: assert property (@(posedge clk) disable iff (rst)
        !iir_q[0] |-> (iir_q[3:1] inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110}));

    assert_idle_code_R3: assert property (@(posedge clk) disable iff (rst)
        iir_q[0] |-> (iir_q[3:1] == 3'b000));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        iir_q[5:4] == 2'b00 && iir_q[7] == iir_q[6]);

    assert_line_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (ls_rd && !ls_evt && !iir_rd) |=> !pend[0]);

    assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && !$past(rst)) |=> ($stable(iir_q) && $stable(irq) && $stable(pend)));

endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .iir_rd (iir_rd),
    .ls_rd  (ls_rd),
    .ls_evt (ls_evt),
    .irq    (irq),
    .iir_q  (iir_q),
    .pend   (pend)
);

// File: tb/test_uart_irq_id.sv
`timescale 1ns/1ps
module test_uart_irq_id;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_mode = 1'b0;
    logic [4:0] src_en = 5'b11111;
    logic       ls_evt = 0, ls_rd = 0, rx_at_trig = 0, tmo_evt = 0, rxf_rd = 0;
    logic       thre_evt = 0, thr_wr = 0, ms_evt = 0, msr_rd = 0, iir_rd = 0;
    logic [7:0] iir_q;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_irq_id i_uart_irq_id (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .src_en(src_en),
        .ls_evt(ls_evt), .ls_rd(ls_rd), .rx_at_trig(rx_at_trig),
        .tmo_evt(tmo_evt), .rxf_rd(rxf_rd), .thre_evt(thre_evt),
        .thr_wr(thr_wr), .ms_evt(ms_evt), .msr_rd(msr_rd),
        .iir_rd(iir_rd), .iir_q(iir_q), .irq(irq)
    );

    // Behavioural reference model
    bit [4:0] m_p, m_cap;
    bit [7:0] m_iir = 8'h01;
    bit       m_irq, m_rdq;

    function automatic bit [2:0] code_of(int k);
        case (k)
            0: return 3'b011;
            1: return 3'b010;
            2: return 3'b110;
            3: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [4:0] ev;
        bit [4:0] cl;
        bit       ack;
        int       best;
        ev = {ms_evt, thre_evt, tmo_evt, 1'b0, ls_evt};
        if (rst) begin
            m_p = 0; m_cap = 0; m_iir = 8'h01; m_irq = 0; m_rdq = 0;
        end else if (iir_rd) begin
            m_cap = m_cap | ev;
            m_rdq = 1;
        end else begin
            ack = m_rdq && !m_iir[0] && (m_iir[3:1] == 3'b001);
            cl  = {msr_rd, thr_wr | ack, rxf_rd, 1'b0, ls_rd};
            m_p = (m_p & ~cl) | ev | m_cap;
            m_p[1] = rx_at_trig;
            m_cap = 0;
            m_rdq = 0;
            best = -1;
            for (int k = 4; k >= 0; k--)
                if (m_p[k] && src_en[k]) best = k;
            m_irq = (best >= 0);
            m_iir = {fifo_mode, fifo_mode, 2'b00,
                     (best >= 0) ? code_of(best) : 3'b000, (best < 0)};
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (iir_q !== m_iir || irq !== m_irq) begin
                errors++;
                $display("FAIL R2/R3 model compare at %0t: iir=%h irq=%b expected iir=%h irq=%b",
                         $time, iir_q, irq, m_iir, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ls_evt = 0; ls_rd = 0; tmo_evt = 0; rxf_rd = 0;
        thre_evt = 0; thr_wr = 0; ms_evt = 0; msr_rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        chk("R1 reset iir", iir_q, 8'h01);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);

        // R12: no change before the edge
        ms_evt = 1; #1;
        chk("R12 before edge", iir_q, 8'h01);
        step();
        chk("R3 modem code", iir_q, 8'h00);
        chk("R2 irq set", {7'b0, irq}, 8'h01);
        msr_rd = 1; step();
        chk("R7 modem clear", iir_q, 8'h01);

        fifo_mode = 1;
        thre_evt = 1; step();
        chk("R5 fifo bits thre", iir_q, 8'hC2);
        thr_wr = 1; step();
        chk("R9 thr write clear", iir_q, 8'hC1);

        // Priority
        ms_evt = 1; thre_evt = 1; tmo_evt = 1; ls_evt = 1; rx_at_trig = 1; step();
        chk("R4 line first", iir_q, 8'hC6);
        ls_rd = 1; step();
        chk("R4 rxd over timeout", iir_q, 8'hC4);
        rx_at_trig = 0; step();
        chk("R8 level drop", iir_q, 8'hCC);
        rxf_rd = 1; step();
        chk("R8 fifo read clears timeout", iir_q, 8'hC2);

        // Frozen access reporting thre
        iir_rd = 1; ls_evt = 1; step();
        chk("R10 frozen", iir_q, 8'hC2);
        step();
        chk("R10 still frozen", iir_q, 8'hC2);
        iir_rd = 0; step();
        chk("R10 captured event", iir_q, 8'hC6);
        ls_rd = 1; step();
        chk("R9 reported thre acked", iir_q, 8'hC0);
        msr_rd = 1; step();
        chk("R7 modem clear 2", iir_q, 8'hC1);

        // Access not reporting thre
        thre_evt = 1; ls_evt = 1; step();
        iir_rd = 1; step();
        iir_rd = 0; step();
        chk("R9 line kept", iir_q, 8'hC6);
        ls_rd = 1; step();
        chk("R9 unreported thre kept", iir_q, 8'hC2);

        // Set wins over clear
        thr_wr = 1; thre_evt = 1; step();
        chk("R11 set wins", iir_q, 8'hC2);
        thr_wr = 1; step();
        chk("R9 clear", iir_q, 8'hC1);

        // Enable masking
        src_en = 5'b11110; ls_evt = 1; step();
        chk("R6 masked", iir_q, 8'hC1);
        chk("R6 masked irq", {7'b0, irq}, 8'h00);
        src_en = 5'b11111; step();
        chk("R6 kept pending", iir_q, 8'hC6);
        ls_rd = 1; step();
        chk("R7 line clear", iir_q, 8'hC1);

        // Clear strobe ignored during access
        ms_evt = 1; step();
        iir_rd = 1; msr_rd = 1; step();
        iir_rd = 0; step();
        chk("R10 clear ignored", iir_q, 8'hC0);
        msr_rd = 1; step();
        chk("R7 final clear", iir_q, 8'hC1);

        step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule